// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Activity Indicators

This block is an eight-pin general-purpose I/O controller. Software configures each pin through a small register port. A pin can be an input, an open-drain output or a push-pull output. For every pin the block produces an output level and an output enable, which drive an external pad. The pad levels come back on `pin_in`. They pass through a two-stage synchronizer before software can read them.

Pin 0 and pin 1 can each be switched to an alternate role as a bus activity indicator. Pin 0 follows `tx_busy` and pin 1 follows `rx_busy`. An indicator rests high while its busy input is low. While its busy input is high, it toggles at a slow fixed rate taken from a prescaler on the system clock.

A suspend input freezes the visible pin state. While suspend is high, register writes are dropped and both indicators hold their level and their prescaler count.

Top module: `gpio_activity_port`

## Requirements
- R1: After reset every register reads 0 and every pin has `pin_oe` = 0. This means all pins are inputs and no alternate function is enabled. Both indicators start at level 1.
- R2: The register map uses `reg_addr` 0 for direction (bit=1 output), 1 for drive mode (bit=1 push-pull, 0 open-drain), 2 for the output latch, 3 for alternate enables and 4 for the synchronized pin levels (read-only). Other addresses read 0. A write updates the register on the clock edge where `reg_we` is high. The written value reads back on `reg_rdata` combinationally.
- R3: A push-pull output pin has `pin_oe`=1 and `pin_out` equal to its latch bit.
- R4: An open-drain output pin with latch 1 has `pin_oe`=0. With latch 0 it has `pin_oe`=1 and `pin_out`=0. An open-drain pin never has `pin_oe`=1 together with `pin_out`=1.
- R5: A change on `pin_in` is not yet visible at address 4 after one rising edge. It is visible after the second rising edge.
- R6: Alternate-enable bit 0 makes pin 0 the transmit indicator and bit 1 makes pin 1 the receive indicator. The pin is then treated as an output whatever its direction bit, and its drive-mode bit still applies. Bits above 1 of the alternate register are ignored and read 0.
- R7: When a busy input is low and suspend is low, its indicator is 1 after the next edge, and its prescaler is cleared.
- R8: With busy high, the indicator inverts on every HALF-th rising edge, counted from the first edge that samples busy high. HALF = CLK_HZ/(2*TOGGLE_HZ).
- R9: While `suspend` is high, register writes are ignored. The indicator levels and their prescaler counts hold, and counting resumes where it stopped.
- R10: An input pin (direction 0, no alternate) has `pin_oe`=0 whatever its latch and mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend | input | 1 | Holds register and indicator state while high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_busy | input | 1 | Transmit activity status |
| rx_busy | input | 1 | Receive activity status |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |

## Verification
The drive logic is tried with several direction, mode and latch patterns:
- all push-pull;
- all open-drain;
- all input;
- two mixed nibble patterns.

Together these separate a swap of the mode polarity, a direction mask that is ignored, and an open-drain pin that drives high.

The indicators are tried with busy idle, busy steady across two toggle periods, and busy interrupted by suspend. These runs expose an off-by-one prescaler, a counter that is not cleared, and a freeze that loses the count. A pin-level step tells apart a one-stage synchronizer from a two-stage one.

// File: rtl/gpio_act_pkg.sv
package gpio_act_pkg;
   localparam int ADDR_W = 3;
   localparam int ALT_PINS = 2;
   typedef enum logic [ADDR_W-1:0] {
      A_DIR   = 3'd0,
      A_MODE  = 3'd1,
      A_LATCH = 3'd2,
      A_ALT   = 3'd3,
      A_PINS  = 3'd4
   } gpio_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_act_toggle.sv
module gpio_act_toggle #(
   parameter int HALF = 2400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic suspend,
   input  logic busy,
   output logic ind_o
);
   generate
      if (HALF < 2) begin : g_bad
         $error("gpio_act_toggle: HALF must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ind_o <= 1'b1;
      end else if (!suspend) begin
         if (!busy) begin
            cnt_q <= '0;
            ind_o <= 1'b1;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            ind_o <= ~ind_o;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R7
   ind_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !suspend) |=> (ind_o && cnt_q == '0));
   // R9
   ind_suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> ($stable(ind_o) && $stable(cnt_q)));
   // R8
   ind_flip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !suspend && cnt_q != LAST) |=> $stable(ind_o));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
   input  logic dir_bit,
   input  logic pp_bit,
   input  logic latch_bit,
   input  logic alt_en,
   input  logic alt_lvl,
   output logic out_o,
   output logic oe_o
);
   logic as_out;
   logic lvl;

   always_comb begin
      as_out = dir_bit | alt_en;
      lvl    = alt_en ? alt_lvl : latch_bit;
      if (!as_out) begin
         out_o = 1'b0;
         oe_o  = 1'b0;
      end else if (pp_bit) begin
         out_o = lvl;
         oe_o  = 1'b1;
      end else begin
         out_o = 1'b0;
         oe_o  = ~lvl;
      end
   end

   // R4
   always_comb begin
      od_never_high_chk: assert (pp_bit || !(oe_o && out_o));
   end
   // R10
   always_comb begin
      input_released_chk: assert (dir_bit || alt_en || !oe_o);
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_act_pkg::*;
#(
   parameter int PIN_COUNT = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 suspend,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [PIN_COUNT-1:0] wdata,
   input  logic [PIN_COUNT-1:0] pins_sync,
   output logic [PIN_COUNT-1:0] rdata,
   output logic [PIN_COUNT-1:0] dir_q,
   output logic [PIN_COUNT-1:0] mode_q,
   output logic [PIN_COUNT-1:0] latch_q,
   output logic [ALT_PINS-1:0]  alt_q
);
   logic wr_ok;
   assign wr_ok = we && !suspend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         mode_q  <= '0;
         latch_q <= '0;
         alt_q   <= '0;
      end else if (wr_ok) begin
         case (gpio_addr_e'(addr))
            A_DIR:   dir_q   <= wdata;
            A_MODE:  mode_q  <= wdata;
            A_LATCH: latch_q <= wdata;
            A_ALT:   alt_q   <= wdata[ALT_PINS-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (gpio_addr_e'(addr))
         A_DIR:   rdata = dir_q;
         A_MODE:  rdata = mode_q;
         A_LATCH: rdata = latch_q;
         A_ALT:   rdata = {{(PIN_COUNT-ALT_PINS){1'b0}}, alt_q};
         A_PINS:  rdata = pins_sync;
         default: rdata = '0;
      endcase
   end

   // R9
   regs_suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> ($stable(dir_q) && $stable(mode_q) && $stable(latch_q) && $stable(alt_q)));
   // R2
   regs_no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(dir_q) && $stable(mode_q) && $stable(latch_q) && $stable(alt_q)));
endmodule

// File: rtl/gpio_activity_port.sv
module gpio_activity_port
   import gpio_act_pkg::*;
#(
   parameter int PIN_COUNT = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CLK_HZ = 48000000,
   parameter int TOGGLE_HZ = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 suspend,
   input  logic                 reg_we,
   input  logic [2:0]           reg_addr,
   input  logic [PIN_COUNT-1:0] reg_wdata,
   output logic [PIN_COUNT-1:0] reg_rdata,
   input  logic                 tx_busy,
   input  logic                 rx_busy,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);
   localparam int HALF = CLK_HZ / (2 * TOGGLE_HZ);

   generate
      if (PIN_COUNT < ALT_PINS) begin : g_bad_pins
         $error("gpio_activity_port: PIN_COUNT below alternate pin count");
      end
      if (TOGGLE_HZ < 1 || HALF < 2) begin : g_bad_rate
         $error("gpio_activity_port: toggle rate too high for clock");
      end
   endgenerate

   logic [PIN_COUNT-1:0] pins_sync;
   logic [PIN_COUNT-1:0] dir_q, mode_q, latch_q;
   logic [ALT_PINS-1:0]  alt_q;
   logic [ALT_PINS-1:0]  ind;
   logic [ALT_PINS-1:0]  busy_v;

   assign busy_v = {rx_busy, tx_busy};

   gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(pins_sync)
   );

   gpio_regfile #(.PIN_COUNT(PIN_COUNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .suspend(suspend), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .pins_sync(pins_sync), .rdata(reg_rdata),
      .dir_q(dir_q), .mode_q(mode_q), .latch_q(latch_q), .alt_q(alt_q)
   );

   generate
      for (genvar a = 0; a < ALT_PINS; a++) begin : g_ind
         gpio_act_toggle #(.HALF(HALF)) u_tog (
            .clk(clk), .rst_n(rst_n), .suspend(suspend),
            .busy(busy_v[a]), .ind_o(ind[a])
         );
      end
      for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
         if (i < ALT_PINS) begin : g_alt
            gpio_pin_drive u_drv (
               .dir_bit(dir_q[i]), .pp_bit(mode_q[i]), .latch_bit(latch_q[i]),
               .alt_en(alt_q[i]), .alt_lvl(ind[i]),
               .out_o(pin_out[i]), .oe_o(pin_oe[i])
            );
         end else begin : g_plain
            gpio_pin_drive u_drv (
               .dir_bit(dir_q[i]), .pp_bit(mode_q[i]), .latch_bit(latch_q[i]),
               .alt_en(1'b0), .alt_lvl(1'b1),
               .out_o(pin_out[i]), .oe_o(pin_oe[i])
            );
         end
      end
   endgenerate

   // R1
   reset_all_inputs_chk: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 || rst_n));
endmodule

// File: tb/gpio_activity_port_test.sv
module gpio_activity_port_test;
   localparam int HALF = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic suspend = 1'b0;
   logic reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic tx_busy = 1'b0, rx_busy = 1'b0;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out, pin_oe;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   gpio_activity_port #(.CLK_HZ(200), .TOGGLE_HZ(10)) uut (
      .clk(clk), .rst_n(rst_n), .suspend(suspend), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_busy(tx_busy), .rx_busy(rx_busy), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // vector: dir, mode, latch, expected oe, expected out
   localparam logic [39:0] VEC [5] = '{
      {8'hFF, 8'hFF, 8'hA5, 8'hFF, 8'hA5},  // R3 all push-pull
      {8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h00},  // R4 all open-drain
      {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00},  // R10 all input
      {8'hF0, 8'hCC, 8'hAA, 8'hD0, 8'h80},  // R3 R4 R10 mixed high nibble
      {8'h0F, 8'h33, 8'h55, 8'h0B, 8'h01}   // R3 R4 R10 mixed low nibble
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic edges(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #3_000_000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      edges(3);
      rst_n = 1'b1;
      edges(1);
      // R1 reset state
      chk("R1 oe", pin_oe, 8'h00);
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), r);
         chk("R1 reg", r, 8'h00);
      end

      // R2 readback
      wr(3'd0, 8'h3C); wr(3'd1, 8'hC3); wr(3'd2, 8'h99);
      rd(3'd0, r); chk("R2 dir", r, 8'h3C);
      rd(3'd1, r); chk("R2 mode", r, 8'hC3);
      rd(3'd2, r); chk("R2 latch", r, 8'h99);
      rd(3'd6, r); chk("R2 unused", r, 8'h00);

      // table walk: R3 R4 R10
      for (int v = 0; v < 5; v++) begin
         wr(3'd0, VEC[v][39:32]);
         wr(3'd1, VEC[v][31:24]);
         wr(3'd2, VEC[v][23:16]);
         #1;
         chk("R3/R4/R10 oe", pin_oe, VEC[v][15:8]);
         chk("R3/R4/R10 out", pin_out, VEC[v][7:0]);
      end

      // R5 synchronizer latency
      @(negedge clk); pin_in = 8'h6B;
      @(negedge clk); rd(3'd4, r); chk("R5 one edge", r, 8'h00);
      @(negedge clk); rd(3'd4, r); chk("R5 two edges", r, 8'h6B);

      // R6 alternate enable, upper bits ignored
      wr(3'd0, 8'h00); wr(3'd1, 8'hFD); wr(3'd2, 8'h00);
      wr(3'd3, 8'hFF);
      rd(3'd3, r); chk("R6 alt read", r, 8'h03);
      #1;
      chk("R6 R7 idle pp pin0 oe", {7'd0, pin_oe[0]}, 8'h01);
      chk("R6 R7 idle pin0 out", {7'd0, pin_out[0]}, 8'h01);
      chk("R6 R7 idle od pin1 released", {7'd0, pin_oe[1]}, 8'h00);
      chk("R6 other pins input", pin_oe & 8'hFC, 8'h00);

      // R8 tx toggle timing
      tx_busy = 1'b1;
      edges(HALF - 1);
      chk("R8 before first flip", {7'd0, pin_out[0]}, 8'h01);
      edges(1);
      chk("R8 first flip", {7'd0, pin_out[0]}, 8'h00);
      edges(HALF - 1);
      chk("R8 before second flip", {7'd0, pin_out[0]}, 8'h00);
      edges(1);
      chk("R8 second flip", {7'd0, pin_out[0]}, 8'h01);
      edges(3);
      tx_busy = 1'b0;
      edges(1);
      chk("R7 idle returns high", {7'd0, pin_out[0]}, 8'h01);

      // R9 suspend freezes count and writes
      tx_busy = 1'b1;
      edges(5);
      suspend = 1'b1;
      reg_addr = 3'd2; reg_wdata = 8'hFF; reg_we = 1'b1;
      edges(20);
      reg_we = 1'b0;
      rd(3'd2, r); chk("R9 write ignored", r, 8'h00);
      chk("R9 indicator held", {7'd0, pin_out[0]}, 8'h01);
      suspend = 1'b0;
      edges(4);
      chk("R9 count resumed no early flip", {7'd0, pin_out[0]}, 8'h01);
      edges(1);
      chk("R9 flip at resumed count", {7'd0, pin_out[0]}, 8'h00);
      tx_busy = 1'b0;

      // R6 rx indicator on open-drain pin1
      rx_busy = 1'b1;
      edges(HALF);
      chk("R6 R8 rx od drive low oe", {7'd0, pin_oe[1]}, 8'h01);
      chk("R6 R8 rx od drive low out", {7'd0, pin_out[1]}, 8'h00);
      rx_busy = 1'b0;
      edges(1);
      chk("R7 rx idle released", {7'd0, pin_oe[1]}, 8'h00);

      // R1 second reset
      rst_n = 1'b0;
      #1;
      chk("R1 reset again oe", pin_oe, 8'h00);
      rd(3'd3, r); chk("R1 alt cleared", r, 8'h00);
      edges(1);
      rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule